// File: doc/BRIEF.md
# Serial Control Register Loader

This block fills a bank of serial-in control registers from a host bus that moves one bit per write. The host first stores a single data bit in a holding bit by means of a "hold write". It then issues a "shift write". The shift write picks one register through the low address bits and pushes the held bit into that register. Every register is fed by the same held bit. Only the register named by the shift write takes it. Loading a register of W bits therefore takes W pairs of hold and shift writes. Because the held bit stays put between hold writes, one bit can be pushed into several registers in turn.

A write cycle counts only when the block select is low and the write strobe is low. It takes effect on the release of the strobe, which is the low-to-high edge of `wr_n`. The top address bit separates hold writes (bit low) from shift writes (bit high). No clock is derived from the strobe. A single system clock samples `wr_n`, and the block acts in the clock cycle in which it first sees the strobe high again. Select, address and data are taken from the last cycle in which the strobe was low. The register contents appear in parallel as one flat vector of control words.

Top module: `scrl_loader`

## Requirements
- R1: While reset is applied, and after it is released, every control word reads zero and `hold_q` reads zero.
- R2: A hold write stores `bus_d` in `hold_q`. A hold write is `cs_n`=0 and `wr_n`=0 with address bit SEL_W (bit 3 by default) at 0, followed by `wr_n` returning to 1. The stored value is `bus_d` as it stood in the last cycle in which `wr_n` was low.
- R3: A shift write to register k updates word k, which sits at bits [k*WIDTH +: WIDTH] of `ctl_words`. A shift write is `cs_n`=0 and `wr_n`=0 with address bit SEL_W at 1 and address bits [SEL_W-1:0] equal to k, followed by the release of `wr_n`. Word k becomes {old[WIDTH-2:0], hold_q}: the new bit enters at bit 0 and the top bit is dropped. Words therefore load MSB-first.
- R4: A shift write changes only the addressed word. In any one clock cycle, at most one word changes.
- R5: A write cycle made with `cs_n` high changes neither any word nor `hold_q`.
- R6: `hold_q` keeps its value through any number of shift writes, so the same bit can be shifted into several registers.
- R7: The update occurs at the first rising clock edge at which `wr_n` is sampled high after having been sampled low. Before that edge the outputs still hold their old values.
- R8: No word and no holding bit changes unless `wr_n` is released. Toggling `addr`, `bus_d` or `cs_n` while `wr_n` stays high has no effect.
- R9: A hold write leaves all words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Block select, active low |
| wr_n | input | 1 | Write strobe, active low; its release commits the write |
| addr | input | SEL_W+1 | Bits [SEL_W-1:0] pick the register; bit SEL_W picks shift (1) or hold (0) |
| bus_d | input | 1 | Data bit for hold writes |
| hold_q | output | 1 | The holding bit shared by all registers |
| ctl_words | output | NREG*WIDTH | All control words; word k at [k*WIDTH +: WIDTH] |

## Verification
Every result is due one clock edge after the strobe release is sampled. The bench drives `wr_n` high on a falling edge and reads the new word or holding bit on the next falling edge, after the single rising edge in between. The R7 check also reads the outputs just before that rising edge to confirm they still hold their old values. A behavioural model in the bench tracks the holding bit and every word, and is compared with the design on every falling edge. The model starts comparing only after the two cycles of internal reset release.

// File: rtl/scrl_pkg.sv
package scrl_pkg;
  // What a completed bus write does once the strobe is released.
  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_HOLD  = 2'd1,
    WK_SHIFT = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/scrl_rst_sync.sv
module scrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/scrl_wr_edge.sv
module scrl_wr_edge
  import scrl_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [SEL_W:0]   addr,
  input  logic             bus_d,
  output wr_kind_e         kind_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             bit_o
);
  logic             wr_q;
  logic             snap_cs_n_q, snap_cs_n_d;
  logic [SEL_W:0]   snap_addr_q, snap_addr_d;
  logic             snap_d_q, snap_d_d;
  logic             snap_en;
  logic             release_seen;

  // Bus fields are held while the strobe is low.
  assign snap_en = ~wr_n;

  always_comb begin
    snap_cs_n_d = snap_cs_n_q;
    snap_addr_d = snap_addr_q;
    snap_d_d    = snap_d_q;
    if (snap_en) begin
      snap_cs_n_d = cs_n;
      snap_addr_d = addr;
      snap_d_d    = bus_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q        <= 1'b1;
      snap_cs_n_q <= 1'b1;
      snap_addr_q <= '0;
      snap_d_q    <= 1'b0;
    end else begin
      wr_q        <= wr_n;
      snap_cs_n_q <= snap_cs_n_d;
      snap_addr_q <= snap_addr_d;
      snap_d_q    <= snap_d_d;
    end
  end

  assign release_seen = ~wr_q & wr_n;

  always_comb begin
    kind_o = WK_NONE;
    if (release_seen && !snap_cs_n_q) begin
      kind_o = snap_addr_q[SEL_W] ? WK_SHIFT : WK_HOLD;
    end
  end

  assign sel_o = snap_addr_q[SEL_W-1:0];
  assign bit_o = snap_d_q;
endmodule

// File: rtl/scrl_strobe_dec.sv
module scrl_strobe_dec
  import scrl_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int SEL_W = 3
) (
  input  wr_kind_e         kind_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NREG-1:0]  stb_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    assign stb_o[g] = (kind_i == WK_SHIFT) && (sel_i == IDX);
  end
endmodule

// File: rtl/scrl_shift_bank.sv
module scrl_shift_bank #(
  parameter int NREG  = 8,
  parameter int WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic [NREG-1:0]       stb_i,
  input  logic                  din_i,
  output logic [NREG*WIDTH-1:0] words_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] d;

    if (WIDTH == 1) begin : g_one
      always_comb d = stb_i[g] ? din_i : q;
    end else begin : g_many
      always_comb d = stb_i[g] ? {q[WIDTH-2:0], din_i} : q;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign words_o[g*WIDTH +: WIDTH] = q;
  end
endmodule

// File: rtl/scrl_loader.sv
module scrl_loader
  import scrl_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic [SEL_W:0]        addr,
  input  logic                  bus_d,
  output logic                  hold_q,
  output logic [NREG*WIDTH-1:0] ctl_words
);
  logic             rst_sync_n;
  wr_kind_e         kind;
  logic [SEL_W-1:0] sel;
  logic             snap_bit;
  logic [NREG-1:0]  stb;
  logic             hold_d;
  logic             hold_r;

  scrl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  scrl_wr_edge #(.SEL_W(SEL_W)) u_edge (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .bus_d  (bus_d),
    .kind_o (kind),
    .sel_o  (sel),
    .bit_o  (snap_bit)
  );

  scrl_strobe_dec #(.NREG(NREG), .SEL_W(SEL_W)) u_dec (
    .kind_i (kind),
    .sel_i  (sel),
    .stb_o  (stb)
  );

  // Holding bit, shared by every register in the bank.
  always_comb begin
    hold_d = hold_r;
    if (kind == WK_HOLD) hold_d = snap_bit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hold_r <= 1'b0;
    else             hold_r <= hold_d;
  end

  assign hold_q = hold_r;

  scrl_shift_bank #(.NREG(NREG), .WIDTH(WIDTH)) u_bank (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .stb_i   (stb),
    .din_i   (hold_r),
    .words_o (ctl_words)
  );
endmodule

// File: rtl/scrl_loader_chk.sv
module scrl_loader_chk #(
  parameter int NREG  = 8,
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  wr_n,
  input logic [SEL_W:0]        addr,
  input logic                  bus_d,
  input logic                  hold_q,
  input logic [NREG*WIDTH-1:0] ctl_words
);
  logic [NREG*WIDTH-1:0] prev_words;
  logic [NREG-1:0]       word_moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_words <= '0;
    else        prev_words <= ctl_words;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign word_moved[g] = ctl_words[g*WIDTH +: WIDTH] != prev_words[g*WIDTH +: WIDTH];
  end

  // R5
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_n) && wr_n && $past(cs_n)) |=> ($stable(ctl_words) && $stable(hold_q)));

  // R8
  no_release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$past(wr_n) && wr_n) |=> ($stable(ctl_words) && $stable(hold_q)));

  // R9
  hold_write_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_n) && wr_n && !$past(cs_n) && !$past(addr[SEL_W])) |=> $stable(ctl_words));

  // R2
  hold_write_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_n) && wr_n && !$past(cs_n) && !$past(addr[SEL_W])) |=> (hold_q == $past(bus_d, 2)));

  // R6
  shift_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_n) && wr_n && !$past(cs_n) && $past(addr[SEL_W])) |=> $stable(hold_q));

  // R4
  single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_moved));
endmodule

bind scrl_loader scrl_loader_chk #(.NREG(NREG), .WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_scrl_loader.sv
module sim_scrl_loader;
  localparam int NREG  = 8;
  localparam int WIDTH = 8;
  localparam int SEL_W = 3;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  cs_n = 1'b1;
  logic                  wr_n = 1'b1;
  logic [SEL_W:0]        addr = '0;
  logic                  bus_d = 1'b0;
  logic                  hold_q;
  logic [NREG*WIDTH-1:0] ctl_words;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  scrl_loader #(.NREG(NREG), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .bus_d(bus_d), .hold_q(hold_q), .ctl_words(ctl_words)
  );

  // Behavioural reference model
  logic [WIDTH-1:0] mw [NREG];
  logic             mhold, mwq, mscs, msd;
  logic [SEL_W:0]   msa;
  int               rcnt = 0;

  always @(posedge clk) begin
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt++;
      for (int i = 0; i < NREG; i++) mw[i] = '0;
      mhold = 0; mwq = 1; mscs = 1; msd = 0; msa = '0;
    end else begin
      if (!mwq && wr_n && !mscs) begin
        if (msa[SEL_W]) mw[msa[SEL_W-1:0]] = {mw[msa[SEL_W-1:0]][WIDTH-2:0], mhold};
        else            mhold = msd;
      end
      if (!wr_n) begin mscs = cs_n; msa = addr; msd = bus_d; end
      mwq = wr_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rcnt >= 2) begin
      total++;
      if (hold_q !== mhold) begin
        bad++;
        $display("FAIL model R2/R6 hold actual=%0b expected=%0b", hold_q, mhold);
      end
      for (int i = 0; i < NREG; i++) begin
        total++;
        if (ctl_words[i*WIDTH +: WIDTH] !== mw[i]) begin
          bad++;
          $display("FAIL model R3/R4 word%0d actual=%h expected=%h", i, ctl_words[i*WIDTH +: WIDTH], mw[i]);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] word(input int k);
    return ctl_words[k*WIDTH +: WIDTH];
  endfunction

  task automatic bus_wr(input logic c, input logic [SEL_W:0] a, input logic d);
    @(negedge clk); cs_n = c; addr = a; bus_d = d; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic hold_wr(input logic d);
    bus_wr(1'b0, {1'b0, {SEL_W{1'b0}}}, d);
  endtask

  task automatic shift_wr(input int k);
    bus_wr(1'b0, {1'b1, SEL_W'(k)}, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 words in reset", 64'(ctl_words), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 words after reset", 64'(ctl_words), 64'd0);
    chk("R1 hold after reset", 64'(hold_q), 64'd0);

    hold_wr(1);
    chk("R2 hold write stores 1", 64'(hold_q), 64'd1);
    chk("R9 hold write keeps words", 64'(ctl_words), 64'd0);

    shift_wr(3);
    hold_wr(0); shift_wr(3);
    hold_wr(1); shift_wr(3);
    shift_wr(3);
    chk("R3 word3 MSB-first 1011", 64'(word(3)), 64'h0B);
    chk("R4 word2 untouched", 64'(word(2)), 64'd0);
    chk("R4 word4 untouched", 64'(word(4)), 64'd0);

    shift_wr(0); shift_wr(7);
    chk("R6 same bit into word0", 64'(word(0)), 64'd1);
    chk("R6 same bit into word7", 64'(word(7)), 64'd1);
    chk("R6 hold kept", 64'(hold_q), 64'd1);

    bus_wr(1'b1, {1'b1, 3'd0}, 1'b0);
    bus_wr(1'b1, {1'b0, 3'd0}, 1'b0);
    chk("R5 deselected shift ignored", 64'(word(0)), 64'd1);
    chk("R5 deselected hold ignored", 64'(hold_q), 64'd1);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk); cs_n = i[0]; addr = 4'(i); bus_d = i[1];
    end
    @(negedge clk); cs_n = 1;
    chk("R8 word3 after toggles", 64'(word(3)), 64'h0B);
    chk("R8 hold after toggles", 64'(hold_q), 64'd1);

    @(negedge clk); cs_n = 0; addr = {1'b1, 3'd1}; wr_n = 0;
    @(negedge clk); wr_n = 1;
    #5;
    chk("R7 word1 before edge", 64'(word(1)), 64'd0);
    @(negedge clk); cs_n = 1;
    chk("R7 word1 after edge", 64'(word(1)), 64'd1);

    for (int b = WIDTH - 1; b >= 0; b--) begin
      hold_wr(((8'hA5 >> b) & 8'h01) != 0);
      shift_wr(5);
    end
    chk("R3 word5 full load", 64'(word(5)), 64'hA5);
    hold_wr(1); shift_wr(5);
    chk("R3 word5 top bit drops", 64'(word(5)), 64'h4B);
    hold_wr(0);
    chk("R9 word5 after hold write", 64'(word(5)), 64'h4B);
    chk("R2 hold write stores 0", 64'(hold_q), 64'd0);

    @(negedge clk); rst_n = 0;
    #3;
    chk("R1 async clear", 64'(ctl_words), 64'd0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 words after second reset", 64'(ctl_words), 64'd0);
    chk("R1 hold after second reset", 64'(hold_q), 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule